// File: doc/BRIEF.md
# DMA Transfer List Job Sequencer

This block steps one DMA job through its list of transfer records. A pulse on the start input latches a first slot index. The sequencer then fetches the record in that slot over a simple request/valid port and unpacks it. It hands the count, element size, burst type and address modes to a separate transfer executor and waits for the executor's completion pulse. It then moves on to the next slot. A record whose last flag is set ends the job. When the index passes the final slot it returns to the slot the job started from, so a list with no last flag repeats for as long as the job runs.

The block also drives the job's hardware request/acknowledge handshake with a peripheral. When flow control is on, no transfer starts until the peripheral's request is high. The acknowledge rises only after a finished transfer whose record asks for it. An executor error stops the job, sets a sticky error bit and raises the interrupt. The error bit stays set until a write-one-to-clear strobe.

Top module: `dmaseq_job_sequencer`

## Requirements
- R1: After reset the sequencer is idle. `busy_o`, `job_done_o`, `rec_req_o`, `xfer_start_o`, `hw_ack_o`, `err_state_o` and `irq_o` are all low.
- R2: A `job_start_i` pulse loads `job_ptr_i` as the first slot. Records are then fetched and executed in ascending slot order from that slot.
- R3: The record word is decoded as: count in bits [15:0], element size in [17:16], acknowledge-enable in bit 18, last flag in bit 19, burst type in [21:20], destination address mode in [23:22], source address mode in [25:24]. The executor outputs carry the count, element size, burst and both modes of the record being executed.
- R4: When a record with the last flag set completes without error, `job_done_o` pulses for one cycle and `busy_o` falls. No further record is fetched.
- R5: After the slot numbered NUM_SLOTS-1, the next slot is the job's start slot, not slot 0. If no record carries the last flag, the list repeats without end.
- R6: While `flow_en_i` is high, no transfer starts while `hw_req_i` is low. While `flow_en_i` is low, `hw_req_i` has no effect on when transfers start.
- R7: `hw_ack_o` goes high only when `hw_req_i` is high, `flow_en_i` is high, a transfer has finished, and that transfer's record has acknowledge-enable set. If any of these is missing, it stays low.
- R8: `hw_ack_o` is low in the cycle after any cycle in which `hw_req_i` is low.
- R9: A completion with `xfer_err_i` high sets `err_state_o` and `irq_o` and ends the job without a `job_done_o` pulse. The error bit stays set until it is cleared.
- R10: An `err_clr_i` pulse clears the error bit in the next cycle. If an error arrives in the same cycle as the clear, the error bit is set.
- R11: A `job_start_i` pulse while the sequencer is busy is ignored. The running job keeps its start slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_start_i | input | 1 | Start pulse for the job |
| job_ptr_i | input | PTR_W | First slot of the job |
| flow_en_i | input | 1 | Hardware flow control enable |
| busy_o | output | 1 | Job in progress |
| job_done_o | output | 1 | One-cycle pulse when the job completes |
| rec_req_o | output | 1 | Record fetch request |
| rec_idx_o | output | PTR_W | Slot being fetched |
| rec_vld_i | input | 1 | Record data valid |
| rec_data_i | input | REC_W | Record word |
| xfer_start_o | output | 1 | One-cycle pulse that starts the executor |
| xfer_count_o | output | CNT_W | Element count code |
| xfer_esize_o | output | 2 | Element size code |
| xfer_burst_o | output | 2 | Burst type code |
| xfer_src_mode_o | output | 2 | Source address mode |
| xfer_dst_mode_o | output | 2 | Destination address mode |
| xfer_done_i | input | 1 | Executor completion pulse |
| xfer_err_i | input | 1 | Error flag, valid with `xfer_done_i` |
| hw_req_i | input | 1 | Peripheral request |
| hw_ack_o | output | 1 | Acknowledge to the peripheral |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error bit |
| err_state_o | output | 1 | Sticky error state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the sequencer with NUM_SLOTS set to 4. With four slots, a job that starts in the middle of the list reaches the last slot after a couple of records, so the wrap back to the start slot and the endless repeat both show up within a few dozen cycles. The record word and count width keep their default values, so every field position in R3 is exercised at its real offset.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    localparam int CNT_W   = 16;
    localparam int ESZ_W   = 2;
    localparam int BURST_W = 2;
    localparam int MODE_W  = 2;
    localparam int REC_W   = CNT_W + ESZ_W + 2 + BURST_W + 2 * MODE_W;

    // Field order, MSB first, sets the bit positions of the record word
    typedef struct packed {
        logic [MODE_W-1:0]  src_mode;
        logic [MODE_W-1:0]  dst_mode;
        logic [BURST_W-1:0] burst;
        logic               last;
        logic               ack_en;
        logic [ESZ_W-1:0]   esize;
        logic [CNT_W-1:0]   count;
    } rec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_LAUNCH,
        S_RUN
    } seq_st_e;

endpackage

// File: rtl/dmaseq_slot_step.sv
module dmaseq_slot_step #(
    parameter int NUM_SLOTS = 16,
    localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [PTR_W-1:0] cur_i,
    input  logic [PTR_W-1:0] base_i,
    output logic [PTR_W-1:0] nxt_o
);

    localparam logic [PTR_W-1:0] TOP_SLOT = PTR_W'(NUM_SLOTS - 1);

    always_comb begin
        if (cur_i >= TOP_SLOT) begin
            nxt_o = base_i;
        end else begin
            nxt_o = cur_i + PTR_W'(1);
        end
    end

endmodule

// File: rtl/dmaseq_ack.sv
module dmaseq_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_req_i,
    input  logic flow_en_i,
    input  logic launch_i,
    input  logic fin_i,
    input  logic fin_ack_en_i,
    output logic hw_ack_o
);

    typedef struct packed {
        logic fin;
        logic fin_ack;
        logic ack;
    } ack_s;

    ack_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch_i) begin
            st_d.fin     = 1'b0;
            st_d.fin_ack = 1'b0;
        end else if (fin_i) begin
            st_d.fin     = 1'b1;
            st_d.fin_ack = fin_ack_en_i;
        end
        if (!hw_req_i) begin
            st_d.ack = 1'b0;
        end else if (flow_en_i && st_q.fin && st_q.fin_ack) begin
            st_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hw_ack_o = st_q.ack;

    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_req_i |=> !hw_ack_o);

    a_r7_ack_needs_req_flow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hw_ack_o) |-> $past(hw_req_i && flow_en_i));

endmodule

// File: rtl/dmaseq_err.sv
module dmaseq_err #(
    parameter int ERR_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_i,
    input  logic [ERR_W-1:0] clr_i,
    output logic [ERR_W-1:0] state_o,
    output logic             irq_o
);

    logic [ERR_W-1:0] err_d, err_q;

    for (genvar g = 0; g < ERR_W; g++) begin : g_bit
        always_comb begin
            if (set_i[g]) begin
                err_d[g] = 1'b1;
            end else if (clr_i[g]) begin
                err_d[g] = 1'b0;
            end else begin
                err_d[g] = err_q[g];
            end
        end

        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> state_o[g]);

        a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !state_o[g]);

        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (state_o[g] && !clr_i[g]) |=> state_o[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign state_o = err_q;
    assign irq_o   = |err_q;

    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> irq_o);

endmodule

// File: rtl/dmaseq_job_sequencer.sv
module dmaseq_job_sequencer
    import dmaseq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               job_start_i,
    input  logic [PTR_W-1:0]   job_ptr_i,
    input  logic               flow_en_i,
    output logic               busy_o,
    output logic               job_done_o,
    output logic               rec_req_o,
    output logic [PTR_W-1:0]   rec_idx_o,
    input  logic               rec_vld_i,
    input  logic [REC_W-1:0]   rec_data_i,
    output logic               xfer_start_o,
    output logic [CNT_W-1:0]   xfer_count_o,
    output logic [ESZ_W-1:0]   xfer_esize_o,
    output logic [BURST_W-1:0] xfer_burst_o,
    output logic [MODE_W-1:0]  xfer_src_mode_o,
    output logic [MODE_W-1:0]  xfer_dst_mode_o,
    input  logic               xfer_done_i,
    input  logic               xfer_err_i,
    input  logic               hw_req_i,
    output logic               hw_ack_o,
    input  logic               err_clr_i,
    output logic               err_state_o,
    output logic               irq_o
);

    typedef struct packed {
        seq_st_e          st;
        logic [PTR_W-1:0] idx;
        logic [PTR_W-1:0] base;
        rec_t             rec;
        logic             done;
    } seq_s;

    seq_s             sq_d, sq_q;
    logic [PTR_W-1:0] idx_nxt;
    logic             fin_ok;
    logic             err_hit;
    logic             in_run;

    dmaseq_slot_step #(.NUM_SLOTS(NUM_SLOTS)) i_step (
        .cur_i  (sq_q.idx),
        .base_i (sq_q.base),
        .nxt_o  (idx_nxt)
    );

    assign in_run  = (sq_q.st == S_RUN);
    assign fin_ok  = in_run && xfer_done_i && !xfer_err_i;
    assign err_hit = in_run && xfer_done_i && xfer_err_i;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        unique case (sq_q.st)
            S_IDLE: begin
                if (job_start_i) begin
                    sq_d.idx  = job_ptr_i;
                    sq_d.base = job_ptr_i;
                    sq_d.st   = S_FETCH;
                end
            end
            S_FETCH: begin
                if (rec_vld_i) begin
                    sq_d.rec = rec_t'(rec_data_i);
                    sq_d.st  = S_WAIT;
                end
            end
            S_WAIT: begin
                if (!flow_en_i || hw_req_i) begin
                    sq_d.st = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                sq_d.st = S_RUN;
            end
            S_RUN: begin
                if (err_hit) begin
                    sq_d.st = S_IDLE;
                end else if (fin_ok) begin
                    if (sq_q.rec.last) begin
                        sq_d.st   = S_IDLE;
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.idx = idx_nxt;
                        sq_d.st  = S_FETCH;
                    end
                end
            end
            default: begin
                sq_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q    <= '0;
            sq_q.st <= S_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o          = (sq_q.st != S_IDLE);
    assign job_done_o      = sq_q.done;
    assign rec_req_o       = (sq_q.st == S_FETCH);
    assign rec_idx_o       = sq_q.idx;
    assign xfer_start_o    = (sq_q.st == S_LAUNCH);
    assign xfer_count_o    = sq_q.rec.count;
    assign xfer_esize_o    = sq_q.rec.esize;
    assign xfer_burst_o    = sq_q.rec.burst;
    assign xfer_src_mode_o = sq_q.rec.src_mode;
    assign xfer_dst_mode_o = sq_q.rec.dst_mode;

    dmaseq_ack i_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_req_i     (hw_req_i),
        .flow_en_i    (flow_en_i),
        .launch_i     (xfer_start_o),
        .fin_i        (fin_ok),
        .fin_ack_en_i (sq_q.rec.ack_en),
        .hw_ack_o     (hw_ack_o)
    );

    dmaseq_err #(.ERR_W(1)) i_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_hit),
        .clr_i   (err_clr_i),
        .state_o (err_state_o),
        .irq_o   (irq_o)
    );

    a_r6_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> $past(!flow_en_i || hw_req_i));

    a_r4_last_ends_job: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && xfer_done_i && !xfer_err_i && sq_q.rec.last) |=> (job_done_o && !busy_o));

    a_r9_error_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && xfer_done_i && xfer_err_i) |=> (!job_done_o && !busy_o));

    a_r11_busy_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && job_start_i) |=> $stable(sq_q.base));

    a_r2_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rec_req_o |-> (int'(rec_idx_o) < NUM_SLOTS));

endmodule

// File: tb/test_dmaseq_job_sequencer.sv
`timescale 1ns/1ps
module test_dmaseq_job_sequencer;

    localparam int NS  = 4;
    localparam int PW  = 2;
    localparam int RW  = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          job_start_i = 1'b0;
    logic [PW-1:0] job_ptr_i = '0;
    logic          flow_en_i = 1'b0;
    logic          busy_o, job_done_o, rec_req_o, xfer_start_o, hw_ack_o;
    logic          err_state_o, irq_o;
    logic [PW-1:0] rec_idx_o;
    logic          rec_vld_i = 1'b0;
    logic [RW-1:0] rec_data_i = '0;
    logic [15:0]   xfer_count_o;
    logic [1:0]    xfer_esize_o, xfer_burst_o, xfer_src_mode_o, xfer_dst_mode_o;
    logic          xfer_done_i = 1'b0;
    logic          xfer_err_i = 1'b0;
    logic          hw_req_i = 1'b0;
    logic          err_clr_i = 1'b0;

    always #10 clk = ~clk;

    dmaseq_job_sequencer #(.NUM_SLOTS(NS)) i_dmaseq_job_sequencer (
        .clk(clk), .rst_n(rst_n), .job_start_i(job_start_i), .job_ptr_i(job_ptr_i),
        .flow_en_i(flow_en_i), .busy_o(busy_o), .job_done_o(job_done_o),
        .rec_req_o(rec_req_o), .rec_idx_o(rec_idx_o), .rec_vld_i(rec_vld_i),
        .rec_data_i(rec_data_i), .xfer_start_o(xfer_start_o), .xfer_count_o(xfer_count_o),
        .xfer_esize_o(xfer_esize_o), .xfer_burst_o(xfer_burst_o),
        .xfer_src_mode_o(xfer_src_mode_o), .xfer_dst_mode_o(xfer_dst_mode_o),
        .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i), .hw_req_i(hw_req_i),
        .hw_ack_o(hw_ack_o), .err_clr_i(err_clr_i), .err_state_o(err_state_o), .irq_o(irq_o)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [RW-1:0] mem [NS];
    logic [15:0] lg_cnt [32];
    logic [7:0]  first_fields;
    int          n_log = 0;
    int          n_fetch = 0;
    int          n_done = 0;
    int          ex_cnt = 0;
    logic        perr = 1'b0;
    logic [15:0] err_code = 16'hFFFF;

    // Record word: {src[25:24], dst[23:22], burst[21:20], last[19], ack[18], esize[17:16], count[15:0]}
    function automatic logic [RW-1:0] mk(input logic [15:0] cnt, input logic last,
                                         input logic ack, input logic [1:0] esz,
                                         input logic [1:0] burst, input logic [1:0] src,
                                         input logic [1:0] dst);
        return {src, dst, burst, last, ack, esz, cnt};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Record memory, executor model and event logger
    initial begin
        forever begin
            @(negedge clk);
            if (rec_vld_i) begin
                rec_vld_i = 1'b0;
            end else if (rec_req_o) begin
                rec_vld_i  = 1'b1;
                rec_data_i = mem[rec_idx_o];
                n_fetch++;
            end
            if (xfer_done_i) begin
                xfer_done_i = 1'b0;
                xfer_err_i  = 1'b0;
            end
            if (ex_cnt != 0) begin
                ex_cnt--;
                if (ex_cnt == 0) begin
                    xfer_done_i = 1'b1;
                    xfer_err_i  = perr;
                end
            end
            if (xfer_start_o) begin
                if (n_log == 0) begin
                    first_fields = {xfer_src_mode_o, xfer_dst_mode_o, xfer_burst_o, xfer_esize_o};
                end
                if (n_log < 32) begin
                    lg_cnt[n_log] = xfer_count_o;
                end
                n_log++;
                ex_cnt = 3;
                perr   = (xfer_count_o == err_code);
            end
            if (job_done_o) begin
                n_done++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        job_start_i = 1'b0; flow_en_i = 1'b0; hw_req_i = 1'b0; err_clr_i = 1'b0;
        xfer_done_i = 1'b0; xfer_err_i = 1'b0; rec_vld_i = 1'b0;
        ex_cnt = 0; n_log = 0; n_fetch = 0; n_done = 0; err_code = 16'hFFFF;
        for (int i = 0; i < NS; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_job(input logic [PW-1:0] ptr);
        job_ptr_i = ptr;
        job_start_i = 1'b1;
        @(negedge clk);
        job_start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            if (!busy_o) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 busy", busy_o, 0);
        chk("R1 outputs", {job_done_o, rec_req_o, xfer_start_o, hw_ack_o, err_state_o, irq_o}, 0);
    endtask

    task automatic t_order_last();
        do_reset();
        mem[0] = mk(16'h0A0A, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(16'h0011, 1'b0, 1'b0, 2'd2, 2'd3, 2'd1, 2'd2);
        mem[2] = mk(16'h0022, 1'b0, 1'b0, 2'd1, 2'd1, 2'd0, 2'd0);
        mem[3] = mk(16'h0033, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        start_job(2'd1);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R2 count of transfers", n_log, 3);
        chk("R2 first slot", lg_cnt[0], 16'h0011);
        chk("R2 second slot", lg_cnt[1], 16'h0022);
        chk("R2 third slot", lg_cnt[2], 16'h0033);
        chk("R3 src/dst/burst/esize", first_fields, {2'd1, 2'd2, 2'd3, 2'd2});
        chk("R4 job_done pulses", n_done, 1);
        chk("R4 no fetch after last", n_fetch, 3);
        chk("R4 busy low", busy_o, 0);
    endtask

    task automatic t_loop();
        do_reset();
        mem[0] = mk(16'h000C, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(16'h001D, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[2] = mk(16'h002A, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[3] = mk(16'h003B, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        start_job(2'd2);
        repeat (100) @(negedge clk);
        chk("R5 still busy", busy_o, 1);
        chk("R5 repeats at least 6", (n_log >= 6), 1);
        for (int i = 0; i < 6; i++) begin
            chk("R5 wrap to start slot", lg_cnt[i], (i % 2 == 0) ? 16'h002A : 16'h003B);
        end
    endtask

    task automatic t_flow();
        do_reset();
        mem[0] = mk(16'h0040, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[3] = mk(16'h0043, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        flow_en_i = 1'b1;
        start_job(2'd0);
        repeat (20) @(negedge clk);
        chk("R6 no start without req", n_log, 0);
        chk("R6 waiting busy", busy_o, 1);
        start_job(2'd3);
        hw_req_i = 1'b1;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R6 started after req", n_log, 1);
        chk("R11 start while busy ignored", lg_cnt[0], 16'h0040);
        chk("R7 no ack when ack_en clear", hw_ack_o, 0);
    endtask

    task automatic t_ack();
        do_reset();
        mem[0] = mk(16'h0050, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0);
        flow_en_i = 1'b1;
        hw_req_i  = 1'b1;
        chk("R7 ack low before transfer", hw_ack_o, 0);
        start_job(2'd0);
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R7 ack after finished transfer", hw_ack_o, 1);
        hw_req_i = 1'b0;
        @(negedge clk);
        chk("R8 ack drops with req", hw_ack_o, 0);
        hw_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 ack returns while finished", hw_ack_o, 1);
        do_reset();
        mem[0] = mk(16'h0051, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0);
        hw_req_i = 1'b1;
        start_job(2'd0);
        wait_idle();
        repeat (5) @(negedge clk);
        chk("R6 req ignored without flow", n_log, 1);
        chk("R7 no ack without flow_en", hw_ack_o, 0);
    endtask

    task automatic t_err();
        do_reset();
        mem[0] = mk(16'h0060, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[1] = mk(16'h0061, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        mem[2] = mk(16'h0062, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        err_code = 16'h0061;
        start_job(2'd0);
        wait_idle();
        chk("R9 error state set", err_state_o, 1);
        chk("R9 irq set", irq_o, 1);
        chk("R9 no job_done", n_done, 0);
        chk("R9 job stopped", n_log, 2);
        repeat (10) @(negedge clk);
        chk("R9 error sticky", err_state_o, 1);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        chk("R10 cleared", {err_state_o, irq_o}, 0);
        do_reset();
        mem[0] = mk(16'h0070, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0);
        err_code = 16'h0070;
        err_clr_i = 1'b1;
        start_job(2'd0);
        wait_idle();
        chk("R10 set beats clear", err_state_o, 1);
        err_clr_i = 1'b0;
        @(negedge clk);
        chk("R10 stays set after clear drops", irq_o, 1);
    endtask

    initial begin
        t_reset();
        t_order_last();
        t_loop();
        t_flow();
        t_ack();
        t_err();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule